// File: doc/BRIEF.md
# Picture Tube Start-Up Sequencer

This block brings a picture tube from a cold start into normal display. After a power-fail reset it runs a warm-up phase. In that phase the video outputs stay at ultra-black throughout line scan. A white-level monitor pulse goes out in every vertical blanking interval so that the cathode currents can be measured. An analog comparator outside the block reports, as a flag, when the sensed cathode voltage has passed its threshold.

That flag is looked at only at the end of a vertical blanking interval, so a phase change never happens inside a field. Once it is seen, the monitor pulse stops and the automatic cut-off loop is enabled, but the picture stays blanked. The loop reports settling through a second flag. Blanking is lifted only after that flag has held at a number of consecutive field ends. From then on the block sits in normal operation.

Either the asynchronous power-fail reset or a synchronous storage-reset input returns the sequence to the warm-up phase from any point.

Top module: `tube_startup_seq`

## Requirements
- R1: After the asynchronous reset the block is in warm-up: `cutoffEnable` is 0, `monitorPulse` follows `vBlank` and `blankLine` follows `lineScan`.
- R2: While `cutoffEnable` is 0 or the loop has not yet settled, `blankLine` equals `lineScan` in every cycle.
- R3: `monitorPulse` is high only in warm-up, only while `vBlank` is high, and it is never high together with `cutoffEnable`.
- R4: A field end is a rising clock edge at which `vBlank` is sampled low after having been sampled high at the previous edge. `senseAbove` moves the block out of warm-up only when it is high at a field end; at any other edge it has no effect.
- R5: At the edge that ends warm-up, `cutoffEnable` rises and stays high, and `monitorPulse` stays low in all later blanking intervals until a reset.
- R6: In the settling phase, blanking is released at the field end where `loopSettled` has been high at `SETTLE_FIELDS` consecutive field ends (default 2). A field end with `loopSettled` low starts the tally again from zero. `loopSettled` between field ends has no effect.
- R7: In normal operation `blankLine` is 0, `cutoffEnable` is 1 and `monitorPulse` is 0, whatever the inputs do, until a reset.
- R8: `storeReset` high at a rising edge returns the block to warm-up at that edge from any phase, and it takes priority over any phase advance at the same edge.
- R9: `rst_n` low forces warm-up at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-fail reset, active low |
| storeReset | input | 1 | Synchronous return to warm-up from the storage threshold detector |
| senseAbove | input | 1 | Comparator flag: sensed cathode voltage above threshold |
| loopSettled | input | 1 | Cut-off loop reports settled |
| lineScan | input | 1 | High during active line scan |
| vBlank | input | 1 | High during vertical blanking |
| blankLine | output | 1 | Hold video at ultra-black for the current line-scan cycle |
| monitorPulse | output | 1 | Drive the white monitor pulse in this blanking cycle |
| cutoffEnable | output | 1 | Enable the automatic cut-off loop |

## Verification
The bench builds the block with the default `SETTLE_FIELDS` of 2. With that value, a run of one settled field followed by a broken field, and then exactly two good field ends, is short enough to show both the tally restart and the release edge within a few fields. Comparator and settled flags are pulsed high in the middle of fields and dropped at the field end, to show that only the field-end sample counts. The storage reset is applied in normal operation and the power-fail reset in the middle of a clock period during settling.

// File: rtl/tube_seq_pkg.sv
package tube_seq_pkg;

  typedef enum logic [1:0] {
    PH_WARM   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_RUN    = 2'd2
  } phase_t;

  // control -> datapath
  typedef struct packed {
    logic clrTally;
    logic tallyEn;
  } ctl_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic fieldEnd;
    logic tallyFull;
  } dp_flag_t;

endpackage

// File: rtl/tube_seq_dp.sv
module tube_seq_dp
  import tube_seq_pkg::*;
#(
  parameter int SETTLE_FIELDS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vBlank,
  input  logic        loopSettled,
  input  ctl_strobe_t ctl,
  output dp_flag_t    flags
);

  localparam int TW = (SETTLE_FIELDS > 1) ? $clog2(SETTLE_FIELDS) : 1;
  localparam logic [TW-1:0] LAST = TW'(SETTLE_FIELDS - 1);

  logic          vbPrev;
  logic [TW-1:0] tally;
  logic          fieldEnd;

  assign fieldEnd = vbPrev & ~vBlank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vbPrev <= 1'b0;
    else        vbPrev <= vBlank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally <= '0;
    end else if (ctl.clrTally) begin
      tally <= '0;
    end else if (ctl.tallyEn && fieldEnd) begin
      if (!loopSettled)       tally <= '0;
      else if (tally != LAST) tally <= tally + 1'b1;
    end
  end

  assign flags.fieldEnd  = fieldEnd;
  assign flags.tallyFull = fieldEnd & loopSettled & (tally == LAST);

endmodule

// File: rtl/tube_seq_ctl.sv
module tube_seq_ctl
  import tube_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        storeReset,
  input  logic        senseAbove,
  input  logic        lineScan,
  input  logic        vBlank,
  input  dp_flag_t    flags,
  output ctl_strobe_t ctl,
  output logic        blankLine,
  output logic        monitorPulse,
  output logic        cutoffEnable
);

  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    if (storeReset) begin
      phaseNext = PH_WARM;
    end else begin
      unique case (phase)
        PH_WARM:   if (flags.fieldEnd && senseAbove) phaseNext = PH_SETTLE;
        PH_SETTLE: if (flags.tallyFull)              phaseNext = PH_RUN;
        PH_RUN:    phaseNext = PH_RUN;
        default:   phaseNext = PH_WARM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_WARM;
    else        phase <= phaseNext;
  end

  assign ctl.clrTally = (phase != PH_SETTLE) | storeReset;
  assign ctl.tallyEn  = (phase == PH_SETTLE);

  assign blankLine    = lineScan & (phase != PH_RUN);
  assign monitorPulse = vBlank & (phase == PH_WARM);
  assign cutoffEnable = (phase != PH_WARM);

endmodule

// File: rtl/tube_startup_seq.sv
module tube_startup_seq
  import tube_seq_pkg::*;
#(
  parameter int SETTLE_FIELDS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic storeReset,
  input  logic senseAbove,
  input  logic loopSettled,
  input  logic lineScan,
  input  logic vBlank,
  output logic blankLine,
  output logic monitorPulse,
  output logic cutoffEnable
);

  ctl_strobe_t ctl;
  dp_flag_t    flags;

  tube_seq_dp #(.SETTLE_FIELDS(SETTLE_FIELDS)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .vBlank      (vBlank),
    .loopSettled (loopSettled),
    .ctl         (ctl),
    .flags       (flags)
  );

  tube_seq_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .storeReset   (storeReset),
    .senseAbove   (senseAbove),
    .lineScan     (lineScan),
    .vBlank       (vBlank),
    .flags        (flags),
    .ctl          (ctl),
    .blankLine    (blankLine),
    .monitorPulse (monitorPulse),
    .cutoffEnable (cutoffEnable)
  );

endmodule

// File: rtl/tube_startup_chk.sv
module tube_startup_chk (
  input logic clk,
  input logic rst_n,
  input logic storeReset,
  input logic senseAbove,
  input logic loopSettled,
  input logic lineScan,
  input logic vBlank,
  input logic blankLine,
  input logic monitorPulse,
  input logic cutoffEnable
);

  assert_blank_in_warm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cutoffEnable |-> (blankLine == lineScan));

  assert_monitor_scope_R3: assert property (@(posedge clk) disable iff (!rst_n)
    monitorPulse |-> (vBlank && !cutoffEnable));

  assert_exit_at_field_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cutoffEnable) |-> ($past(senseAbove) && !$past(vBlank) && $past(vBlank, 2)));

  assert_unblank_only_with_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lineScan && !blankLine) |-> cutoffEnable);

  assert_store_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    storeReset |=> !cutoffEnable);

endmodule

bind tube_startup_seq tube_startup_chk u_chk (.*);

// File: tb/tb_tube_startup_seq.sv
`timescale 1ns/100ps
module tb_tube_startup_seq;

  localparam int NFIELD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic storeReset = 1'b0;
  logic senseAbove = 1'b0;
  logic loopSettled = 1'b0;
  logic lineScan = 1'b0;
  logic vBlank = 1'b0;
  logic blankLine, monitorPulse, cutoffEnable;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state: 0 warm, 1 settling, 2 running
  int mPhase = 0;
  int mCount = 0;
  bit mPrevVb = 1'b0;

  always #2.5 clk = ~clk;

  tube_startup_seq #(.SETTLE_FIELDS(NFIELD)) dut (
    .clk(clk), .rst_n(rst_n), .storeReset(storeReset), .senseAbove(senseAbove),
    .loopSettled(loopSettled), .lineScan(lineScan), .vBlank(vBlank),
    .blankLine(blankLine), .monitorPulse(monitorPulse), .cutoffEnable(cutoffEnable)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPhase = 0; mCount = 0; mPrevVb = 1'b0;
    end else begin
      bit fe;
      fe = mPrevVb && !vBlank;
      if (storeReset) begin
        mPhase = 0; mCount = 0;
      end else if (mPhase == 0) begin
        mCount = 0;
        if (fe && senseAbove) mPhase = 1;
      end else if (mPhase == 1 && fe) begin
        if (!loopSettled) mCount = 0;
        else if (mCount + 1 >= NFIELD) mPhase = 2;
        else mCount = mCount + 1;
      end
      mPrevVb = vBlank;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R2 R3 R5 R6 R7)
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      check("R2", blankLine, lineScan && (mPhase != 2), "blankLine vs model");
      check("R3", monitorPulse, vBlank && (mPhase == 0), "monitorPulse vs model");
      check("R5", cutoffEnable, mPhase != 0, "cutoffEnable vs model");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic runField(input bit endSense, input bit endSettled, input bit midVal);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      vBlank = 1'b1; lineScan = 1'b0; senseAbove = midVal; loopSettled = midVal;
    end
    @(negedge clk);
    vBlank = 1'b0; lineScan = 1'b1; senseAbove = endSense; loopSettled = endSettled;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      lineScan = 1'b1; senseAbove = midVal; loopSettled = midVal;
    end
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); vBlank = 1'b1; #1;
    check("R1", cutoffEnable, 1'b0, "cutoff after reset");
    check("R1", monitorPulse, 1'b1, "monitor after reset");
    @(negedge clk); vBlank = 1'b0; lineScan = 1'b1; #1;
    check("R1", blankLine, 1'b1, "blank after reset");

    // comparator high only mid-field: ignored
    runField(1'b0, 1'b0, 1'b1);
    check("R4", cutoffEnable, 1'b0, "mid-field sense ignored");
    // comparator high at field end
    runField(1'b1, 1'b0, 1'b0);
    check("R4", cutoffEnable, 1'b1, "field-end sense taken");
    check("R2", blankLine, 1'b1, "still blanked in settling");
    @(negedge clk); vBlank = 1'b1; lineScan = 1'b0; #1;
    check("R5", monitorPulse, 1'b0, "monitor off after warm-up");

    // one good field end, then a broken one (settled high only mid-field)
    runField(1'b0, 1'b1, 1'b0);
    check("R6", blankLine, 1'b1, "one settled field not enough");
    runField(1'b0, 1'b0, 1'b1);
    check("R6", blankLine, 1'b1, "broken tally");
    runField(1'b0, 1'b1, 1'b0);
    check("R6", blankLine, 1'b1, "tally restarted");
    runField(1'b0, 1'b1, 1'b0);
    check("R6", blankLine, 1'b0, "released after two settled field ends");

    // normal operation ignores inputs
    runField(1'b0, 1'b0, 1'b1);
    check("R7", blankLine, 1'b0, "running stays unblanked");
    check("R7", cutoffEnable, 1'b1, "running keeps loop");

    // storage reset from running
    @(negedge clk); storeReset = 1'b1; vBlank = 1'b0; lineScan = 1'b1;
    @(negedge clk); storeReset = 1'b0; #1;
    check("R8", cutoffEnable, 1'b0, "store reset to warm-up");
    check("R8", blankLine, 1'b1, "store reset reblanks");

    // storage reset wins over a field end with sense high
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); vBlank = 1'b1; lineScan = 1'b0;
    end
    @(negedge clk); vBlank = 1'b0; lineScan = 1'b1; senseAbove = 1'b1; storeReset = 1'b1;
    @(negedge clk); senseAbove = 1'b0; storeReset = 1'b0; #1;
    check("R8", cutoffEnable, 1'b0, "store reset priority");

    // enter settling again, then async power-fail reset mid-period
    runField(1'b1, 1'b0, 1'b0);
    check("R4", cutoffEnable, 1'b1, "re-entered settling");
    @(negedge clk); #0.5;
    rst_n = 1'b0; #0.5;
    check("R9", cutoffEnable, 1'b0, "async reset immediate");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R9", cutoffEnable, 1'b0, "warm-up after reset");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule